// File: doc/BRIEF.md
# Self-Synchronizing Control Frame Generator

This block turns parallel 32-bit control words into a continuous serial stream of control frames for an internal system interface. Each frame carries one word, most significant bit first, one bit per clock. The frame boundaries follow a recovered sync pulse when that pulse is available. When the pulse cannot be recovered, an internal counter that runs modulo the frame length keeps the frame timing.

The serial line has its own output enable, so the line can sit in high impedance. It stays disabled while the interface is powered down. After reset, and after each power-down, it also stays disabled until the internal counter has aligned to the external sync pulse. After that first alignment, a loss of sync does not disable the line. The counter keeps running freely and frames continue without a gap.

Top module: `ctrl_frame_gen`

## Requirements
- R1: A frame is 32 clocks long. The bit in frame position 0 (the first clock after a boundary) is bit 31 of the word, and each later clock carries the next lower bit.
- R2: The word loaded through `ctl_load` is captured at the next frame boundary. If no word was loaded since the previous boundary, the frame is all zeros.
- R3: A valid sync pulse (`sync_pulse` and `sync_valid` both high) that arrives while the block is unlocked, in any position other than 31, restarts the counter. The next clock carries position 0 of a new frame and `locked` stays low.
- R4: A valid sync pulse in frame position 31 sets `locked` from the next clock. From then on, `ser_oe` is high unless power-down is requested.
- R5: While locked, a valid sync pulse in any position other than 31 has no effect on the frame timing, the data or `locked`.
- R6: A sync pulse with `sync_valid` low has no effect.
- R7: `locked` drops at the third consecutive frame boundary that has no valid sync pulse in position 31. The counter keeps running freely.
- R8: Once lock has been reached, `ser_oe` stays high after lock is lost, and frames continue with their data.
- R9: While `pwr_down` is high, `ser_oe` is low and `locked` clears. After power-down ends, `ser_oe` stays low until a new lock occurs, with the counter restarting from zero.
- R10: After reset, `locked` and `ser_oe` are low and the counter is zero, so the first boundary falls 32 clocks after reset is released.
- R11: `ser_out` is low whenever `ser_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_down | input | 1 | Power-down request for the interface |
| sync_pulse | input | 1 | Recovered sync pulse, one clock wide, high in the last bit of a frame |
| sync_valid | input | 1 | High when the recovered sync pulse can be trusted |
| ctl_word | input | 32 | Control word for the next frame |
| ctl_load | input | 1 | Loads `ctl_word` for the next frame |
| ser_out | output | 1 | Serial frame data |
| ser_oe | output | 1 | Output enable for `ser_out` (low means high impedance) |
| locked | output | 1 | High while aligned to the external sync |

## Verification
The assertions check on every cycle that:
- the line is quiet whenever its enable is low;
- power-down clears lock;
- lock implies an enabled output;
- an unlocked valid pulse restarts the counter;
- a locked block ignores pulses in the wrong position;
- lock is only gained or lost at a frame boundary.

The bit order and word capture can only be shown by the bench scenarios, which compare every serial bit with the expected word. The same holds for idle zero frames, the exact boundary at which the third missed pulse removes lock, data continuing after loss of lock, and the line staying disabled after power-down until a new alignment.

// File: rtl/ctrl_frame_gen.sv
module ctrl_frame_gen #(
  parameter int FRAME_BITS = 32,
  parameter int MISS_LIMIT = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pwr_down,
  input  logic                  sync_pulse,
  input  logic                  sync_valid,
  input  logic [FRAME_BITS-1:0] ctl_word,
  input  logic                  ctl_load,
  output logic                  ser_out,
  output logic                  ser_oe,
  output logic                  locked
);
  localparam int CW = $clog2(FRAME_BITS);
  localparam int MW = $clog2(MISS_LIMIT + 1);

  logic [CW-1:0]         cnt;
  logic [FRAME_BITS-1:0] shreg, pend;
  logic                  pend_vld, lock_q, ever_q;
  logic [MW-1:0]         miss;

  wire vpulse   = sync_pulse & sync_valid;
  wire at_end   = cnt == CW'(FRAME_BITS - 1);
  wire reload   = vpulse & ~lock_q & ~at_end;
  wire boundary = at_end | reload;
  wire [FRAME_BITS-1:0] next_word = ctl_load ? ctl_word : (pend_vld ? pend : '0);

  assign ser_oe  = ever_q & ~pwr_down;
  assign ser_out = ser_oe & shreg[FRAME_BITS-1];
  assign locked  = lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= '0;
      pend_vld <= 1'b0;
    end else if (ctl_load && !boundary) begin
      pend     <= ctl_word;
      pend_vld <= 1'b1;
    end else if (boundary && !pwr_down) begin
      pend_vld <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      shreg  <= '0;
      lock_q <= 1'b0;
      ever_q <= 1'b0;
      miss   <= '0;
    end else if (pwr_down) begin
      cnt    <= '0;
      shreg  <= '0;
      lock_q <= 1'b0;
      ever_q <= 1'b0;
      miss   <= '0;
    end else begin
      cnt   <= boundary ? '0 : cnt + 1'b1;
      shreg <= boundary ? next_word : {shreg[FRAME_BITS-2:0], 1'b0};
      if (at_end) begin
        if (vpulse) begin
          lock_q <= 1'b1;
          ever_q <= 1'b1;
          miss   <= '0;
        end else if (lock_q) begin
          if (miss == MW'(MISS_LIMIT - 1)) begin
            lock_q <= 1'b0;
            miss   <= '0;
          end else begin
            miss <= miss + 1'b1;
          end
        end
      end
    end
  end

  // R11
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_oe |-> !ser_out);

  // R9
  pd_clears_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> !locked);

  // R4
  lock_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked && !pwr_down |-> ser_oe);

  // R3
  unlocked_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse && sync_valid && !locked && !pwr_down |=> cnt == '0);

  // R5
  locked_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked && sync_pulse && sync_valid && !at_end && !pwr_down |=> locked);

  // R7
  drop_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) && !$past(pwr_down) |-> cnt == '0);

  // R4
  gain_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> cnt == '0);
endmodule

// File: tb/ctrl_frame_gen_test.sv
module ctrl_frame_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_down = 1'b0;
  logic        sync_pulse = 1'b0;
  logic        sync_valid = 1'b1;
  logic [31:0] ctl_word = '0;
  logic        ctl_load = 1'b0;
  logic        ser_out, ser_oe, locked;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  ctrl_frame_gen uut (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down),
    .sync_pulse(sync_pulse), .sync_valid(sync_valid),
    .ctl_word(ctl_word), .ctl_load(ctl_load),
    .ser_out(ser_out), .ser_oe(ser_oe), .locked(locked)
  );

  always #5 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // pulse driven at frame position pidx (-1 none), with validity pv
  task automatic frame(input logic [31:0] exp, input bit ld, input logic [31:0] nw,
                       input int pidx, input bit pv, input string req);
    for (int i = 0; i < 32; i++) begin
      check({req, " R1 data"}, {31'b0, ser_out}, {31'b0, exp[31-i]});
      check({req, " R8 oe"}, {31'b0, ser_oe}, 32'd1);
      ctl_load   = ld && (i == 0);
      ctl_word   = nw;
      sync_pulse = (i == pidx);
      sync_valid = (i == pidx) ? pv : 1'b1;
      tick();
      ctl_load   = 1'b0;
      sync_pulse = 1'b0;
      sync_valid = 1'b1;
    end
  endtask

  // counter starts at zero; pulse in position 31 must lock at once
  task automatic align_from_zero(input logic [31:0] w, input string req);
    for (int i = 0; i < 31; i++) begin
      ctl_load = (i == 0);
      ctl_word = w;
      tick();
      ctl_load = 1'b0;
      check({req, " oe held low"}, {31'b0, ser_oe}, 32'd0);
      check({req, " R11 line quiet"}, {31'b0, ser_out}, 32'd0);
    end
    sync_pulse = 1'b1;
    tick();
    sync_pulse = 1'b0;
    check({req, " R4 locked"}, {31'b0, locked}, 32'd1);
    check({req, " R4 oe"}, {31'b0, ser_oe}, 32'd1);
  endtask

  task automatic test_reset();
    tick(); tick();
    check("R10 locked", {31'b0, locked}, 32'd0);
    check("R10 oe", {31'b0, ser_oe}, 32'd0);
    check("R11 out", {31'b0, ser_out}, 32'd0);
    rst_n = 1'b1;
    align_from_zero(32'hA5C3_0F81, "R10");
  endtask

  task automatic test_frames();
    frame(32'hA5C3_0F81, 1, 32'h8000_0001, 31, 1, "R1");
    frame(32'h8000_0001, 0, 32'h0, 31, 1, "R2");
    frame(32'h0, 1, 32'h1234_5678, 31, 1, "R2 idle");
    check("R4 still locked", {31'b0, locked}, 32'd1);
  endtask

  task automatic test_locked_ignore();
    frame(32'h1234_5678, 1, 32'hDEAD_BEEF, 5, 1, "R5");
    check("R5 locked", {31'b0, locked}, 32'd1);
    frame(32'hDEAD_BEEF, 1, 32'h0F0F_F0F0, 31, 1, "R5 after");
  endtask

  task automatic test_loss();
    frame(32'h0F0F_F0F0, 1, 32'h1111_2222, -1, 1, "R7 miss1");
    check("R7 locked after 1 miss", {31'b0, locked}, 32'd1);
    frame(32'h1111_2222, 1, 32'h3333_4444, -1, 1, "R7 miss2");
    check("R7 locked after 2 misses", {31'b0, locked}, 32'd1);
    frame(32'h3333_4444, 1, 32'h5555_6666, -1, 1, "R7 miss3");
    check("R7 unlocked after 3 misses", {31'b0, locked}, 32'd0);
    frame(32'h5555_6666, 1, 32'h7777_8888, -1, 1, "R8 freerun");
    check("R8 oe kept", {31'b0, ser_oe}, 32'd1);
  endtask

  task automatic test_invalid_pulse();
    frame(32'h7777_8888, 1, 32'h9999_AAAA, 10, 0, "R6 mid");
    frame(32'h9999_AAAA, 1, 32'hBBBB_CCCC, 31, 0, "R6 end");
    check("R6 no lock", {31'b0, locked}, 32'd0);
  endtask

  task automatic test_reload();
    for (int i = 0; i < 10; i++) begin
      check("R3 pre bits", {31'b0, ser_out}, {31'b0, 32'hBBBB_CCCC >> (31 - i)} & 32'd1);
      ctl_load   = (i == 0);
      ctl_word   = 32'hC001_D00D;
      sync_pulse = (i == 9);
      tick();
      ctl_load   = 1'b0;
      sync_pulse = 1'b0;
    end
    check("R3 not locked", {31'b0, locked}, 32'd0);
    frame(32'hC001_D00D, 1, 32'hFEED_0001, 31, 1, "R3 new frame");
    check("R4 relock", {31'b0, locked}, 32'd1);
  endtask

  task automatic test_power_down();
    pwr_down = 1'b1;
    tick();
    check("R9 oe off", {31'b0, ser_oe}, 32'd0);
    check("R9 out quiet", {31'b0, ser_out}, 32'd0);
    check("R9 lock cleared", {31'b0, locked}, 32'd0);
    tick(); tick();
    pwr_down = 1'b0;
    check("R9 oe low after release", {31'b0, ser_oe}, 32'd0);
    align_from_zero(32'h4242_1818, "R9");
    frame(32'h4242_1818, 0, 32'h0, 31, 1, "R9 after relock");
  endtask

  initial begin
    #2000000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_frames();
    test_locked_ignore();
    test_loss();
    test_invalid_pulse();
    test_reload();
    test_power_down();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule